// File: doc/BRIEF.md
# Serial Audio Slave Receiver

This block receives a two-channel serial audio stream in the standard I2S framing. An external master drives the bit clock and the word-select line. All three serial inputs are asynchronous to the system clock. The block brings them into the system clock domain, follows the word-select line to find slot boundaries, and assembles the serial bits into 16-bit packets. The packet length does not depend on the sample length the master uses. A 32-bit slot therefore gives two packets, and software joins wider samples back together.

Each finished packet goes into a single holding register. The holding register is exposed as a valid/ready stream: `out_valid` means a packet is waiting, and a cycle with both `out_valid` and `out_ready` high consumes it. Each packet carries a channel-side bit taken from the word-select level of its slot. The block has no deeper storage. If a packet finishes while the holding register is still occupied, the new packet is dropped and a sticky overrun flag is raised. An interrupt request follows the occupied state when it is enabled.

Top module: `i2s_slave_rx`

## Requirements
- R1: After reset `out_valid`, `out_ovr` and `irq` are all 0.
- R2: Serial data is sampled on the rising edges of the bit clock, most significant bit first. The first bit of a slot is the one sampled at the second rising edge after the word-select level changes. A 16-bit slot gives one packet whose `out_data[15]` is that first bit.
- R3: A 32-bit slot gives two packets. The first holds bits 31..16 of the slot and the second holds bits 15..0. Both carry the same channel side.
- R4: `out_side` is the word-select level during the slot the packet came from: 0 when word-select is low (left), 1 when it is high (right).
- R5: `out_valid` rises when a packet is stored. A cycle with `out_valid` and `out_ready` both high consumes the packet. If no new packet arrives in that cycle, `out_valid` is 0 in the next cycle.
- R6: If a packet finishes while `out_valid` is 1 and `out_ready` is 0, the new packet is discarded, the stored packet is kept, and `out_ovr` becomes 1.
- R7: `out_ovr` stays set until the next consumed packet, and it is 0 after that cycle.
- R8: If a packet finishes in the same cycle that the stored packet is consumed, the new packet is stored and no overrun is flagged.
- R9: `irq` is 1 exactly when `irq_en` is 1 and a packet is waiting.
- R10: Bits collected at a word-select change that do not fill a whole 16-bit packet are discarded. After enabling, nothing is collected until the first word-select change.
- R11: While `en` is 0 no packet is produced, and the framing state is cleared.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_side` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; 0 idles and clears the framing state |
| irq_en | input | 1 | Enables the interrupt request |
| i2s_bclk | input | 1 | Serial bit clock from the external master (asynchronous) |
| i2s_ws | input | 1 | Word select from the external master (asynchronous) |
| i2s_sd | input | 1 | Serial data (asynchronous) |
| out_valid | output | 1 | A received packet is waiting |
| out_ready | input | 1 | Consumer accepts the waiting packet |
| out_data | output | 16 | Packet data, first received bit in bit 15 |
| out_side | output | 1 | Channel side of the packet (1 = word select high) |
| out_ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen in the same system clock cycle: the consumer can drain the holding register, and the framer can deliver a new packet. The bench first fills the register and leaves it unread. It then completes a second packet and gives a one-cycle `out_ready` pulse at each offset from one to seven cycles after the final bit-clock rising edge. One of these offsets lands exactly on the cycle the packet reaches the buffer. The expected outcome is worked out from the fixed four-cycle path from that bit-clock edge to the buffer. A pulse at or before the delivery cycle must leave the new packet waiting with no overrun. A later pulse must find the new packet already dropped, with the register empty once the old packet has been drained.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;
  localparam int PKT_W = 16;

  typedef struct packed {
    logic             side;
    logic [PKT_W-1:0] data;
  } pkt_t;
endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // flop chain, one row per stage; STAGES must be at least 2
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2s_rx_framer.sv
module i2s_rx_framer
  import i2s_rx_pkg::*;
#(
  parameter int MAX_SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bclk,
  input  logic ws,
  input  logic sd,
  output logic pkt_stb,
  output pkt_t pkt
);
  localparam int CNT_W = $clog2(MAX_SLOT_BITS + 1);
  localparam int SUB_W = $clog2(PKT_W);

  logic             bclk_d;
  logic             seen;
  logic             active;
  logic             ws_prev;
  logic             side;
  logic [CNT_W-1:0] cnt;
  logic [PKT_W-1:0] shreg;

  logic             rise;
  logic             ws_chg;
  logic             take;
  logic             done;
  logic [CNT_W-1:0] cnt_nx;
  logic [PKT_W-1:0] sh_nx;

  always_comb begin
    rise   = bclk & ~bclk_d;
    ws_chg = seen & (ws != ws_prev);
    take   = active && (cnt < CNT_W'(MAX_SLOT_BITS));
    sh_nx  = {shreg[PKT_W-2:0], sd};
    cnt_nx = cnt + 1'b1;
    done   = rise && take && (cnt_nx[SUB_W-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      seen    <= 1'b0;
      active  <= 1'b0;
      ws_prev <= 1'b0;
      side    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      pkt_stb <= 1'b0;
      pkt     <= '0;
    end else begin
      bclk_d  <= bclk;
      pkt_stb <= 1'b0;
      if (!en) begin
        seen   <= 1'b0;
        active <= 1'b0;
        cnt    <= '0;
      end else if (rise) begin
        seen    <= 1'b1;
        ws_prev <= ws;
        // the bit at a change edge still belongs to the closing slot
        if (take) begin
          shreg <= sh_nx;
          cnt   <= cnt_nx;
        end
        if (done) begin
          pkt_stb   <= 1'b1;
          pkt.data  <= sh_nx;
          pkt.side  <= side;
        end
        if (ws_chg) begin
          cnt    <= '0;
          active <= 1'b1;
          side   <= ws;
        end
      end
    end
  end
endmodule

// File: rtl/i2s_rx_buffer.sv
module i2s_rx_buffer
  import i2s_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_stb,
  input  pkt_t in_pkt,
  output logic out_valid,
  input  logic out_ready,
  output pkt_t out_pkt,
  output logic ovr
);
  logic hs;
  logic load;

  always_comb begin
    hs   = out_valid & out_ready;
    load = in_stb & (~out_valid | hs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkt   <= '0;
      ovr       <= 1'b0;
    end else begin
      out_valid <= load | (out_valid & ~hs);
      if (load) out_pkt <= in_pkt;
      if (in_stb && !load) ovr <= 1'b1;
      else if (hs)         ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
  import i2s_rx_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MAX_SLOT_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             irq_en,
  input  logic             i2s_bclk,
  input  logic             i2s_ws,
  input  logic             i2s_sd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PKT_W-1:0] out_data,
  output logic             out_side,
  output logic             out_ovr,
  output logic             irq
);
  logic [2:0] pins_q;
  logic       pkt_stb;
  pkt_t       fr_pkt;
  pkt_t       buf_pkt;

  i2s_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({i2s_bclk, i2s_ws, i2s_sd}),
    .q     (pins_q)
  );

  i2s_rx_framer #(.MAX_SLOT_BITS(MAX_SLOT_BITS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .bclk    (pins_q[2]),
    .ws      (pins_q[1]),
    .sd      (pins_q[0]),
    .pkt_stb (pkt_stb),
    .pkt     (fr_pkt)
  );

  i2s_rx_buffer u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stb    (pkt_stb),
    .in_pkt    (fr_pkt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pkt   (buf_pkt),
    .ovr       (out_ovr)
  );

  assign out_data = buf_pkt.data;
  assign out_side = buf_pkt.side;
  assign irq      = irq_en & out_valid;
endmodule

// File: rtl/i2s_slave_rx_chk.sv
module i2s_slave_rx_chk
  import i2s_rx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PKT_W-1:0] out_data,
  input logic             out_side,
  input logic             out_ovr,
  input logic             irq,
  input logic             pkt_stb,
  input logic [PKT_W-1:0] pkt_data
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !out_ovr && !irq));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_side)));

  a_r5_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !pkt_stb) |=> !out_valid);

  a_r6_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && pkt_stb) |=> (out_ovr && $stable(out_data)));

  a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && pkt_stb) |=> (out_valid && !out_ovr && out_data == $past(pkt_data)));

  a_r7_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ovr && out_valid && out_ready) |=> !out_ovr);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out_valid && irq_en));
endmodule

bind i2s_slave_rx i2s_slave_rx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_en    (irq_en),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_side  (out_side),
  .out_ovr   (out_ovr),
  .irq       (irq),
  .pkt_stb   (pkt_stb),
  .pkt_data  (fr_pkt.data)
);

// File: tb/test_i2s_slave_rx.sv
module test_i2s_slave_rx;
  localparam int H      = 4;   // system clocks per bit-clock half period
  localparam int NTAB   = 6;
  localparam int WDOG   = 100000;

  // entry: {side, wide (32-bit slot), word}
  localparam logic [33:0] TAB [NTAB] = '{
    {1'b0, 1'b0, 32'h0000_A5C3},
    {1'b1, 1'b0, 32'h0000_8001},
    {1'b0, 1'b1, 32'h1234_ABCD},
    {1'b1, 1'b1, 32'hFFFF_0000},
    {1'b0, 1'b0, 32'h0000_7FFE},
    {1'b1, 1'b1, 32'h0F0F_F0F0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        irq_en = 1'b0;
  logic        bclk = 1'b0;
  logic        ws = 1'b1;
  logic        sd = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_side;
  logic        out_ovr;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic cur = 1'b1;
  logic pend = 1'b0;
  logic mon_on = 1'b0;
  int cap_n = 0;
  logic [15:0] cap_d [16];
  logic        cap_s [16];
  logic [15:0] exp_d [16];
  logic        exp_s [16];

  always #10 clk = ~clk;

  i2s_slave_rx i_i2s_slave_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .irq_en    (irq_en),
    .i2s_bclk  (bclk),
    .i2s_ws    (ws),
    .i2s_sd    (sd),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_side  (out_side),
    .out_ovr   (out_ovr),
    .irq       (irq)
  );

  always @(negedge clk) begin
    if (mon_on && out_valid && out_ready && cap_n < 16) begin
      cap_d[cap_n] = out_data;
      cap_s[cap_n] = out_side;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic w, input logic d);
    bclk = 1'b0; ws = w; sd = d;
    repeat (H) @(negedge clk);
    bclk = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic send_slot(input logic w, input logic [31:0] word, input int n);
    bit_cycle(w, pend);
    for (int i = n - 1; i >= 1; i--) bit_cycle(w, word[i]);
    pend = word[0];
    cur = w;
  endtask

  task automatic end_slot();
    bit_cycle(~cur, pend);
    cur = ~cur;
  endtask

  task automatic drain();
    if (out_valid) begin
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", WDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ne;
    repeat (4) @(negedge clk);
    // R1: idle after reset
    chk(!out_valid && !out_ovr && !irq, "R1", {out_valid, out_ovr, irq}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_valid && !out_ovr && !irq, "R1", {out_valid, out_ovr, irq}, 0);

    // table walk: R2 R3 R4 R5 with the consumer always ready
    mon_on = 1'b1;
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) bit_cycle(1'b1, 1'b0);
    ne = 0;
    for (int i = 0; i < NTAB; i++) begin
      if (TAB[i][32]) begin
        send_slot(TAB[i][33], TAB[i][31:0], 32);
        exp_d[ne] = TAB[i][31:16]; exp_s[ne] = TAB[i][33]; ne++;
        exp_d[ne] = TAB[i][15:0];  exp_s[ne] = TAB[i][33]; ne++;
      end else begin
        send_slot(TAB[i][33], TAB[i][31:0], 16);
        exp_d[ne] = TAB[i][15:0];  exp_s[ne] = TAB[i][33]; ne++;
      end
    end
    end_slot();
    repeat (10) @(negedge clk);
    mon_on = 1'b0;
    out_ready = 1'b0;
    chk(cap_n == ne, "R2 count", cap_n, ne);
    for (int i = 0; i < ne && i < cap_n; i++) begin
      chk(cap_d[i] == exp_d[i], "R2/R3 data", cap_d[i], exp_d[i]);
      chk(cap_s[i] == exp_s[i], "R4 side", cap_s[i], exp_s[i]);
    end
    chk(!out_valid, "R5 drained", out_valid, 0);

    // overrun with no consumer: R6 R9 R12, then R7
    irq_en = 1'b1;
    begin
      logic s1;
      s1 = ~cur;
      send_slot(~cur, 32'h1111, 16);
      send_slot(~cur, 32'h2222, 16);
      end_slot();
      repeat (10) @(negedge clk);
      chk(out_valid, "R5 set", out_valid, 1);
      chk(out_ovr, "R6 overrun", out_ovr, 1);
      chk(out_data == 16'h1111, "R6/R12 kept", out_data, 16'h1111);
      chk(out_side == s1, "R12 side", out_side, s1);
      chk(irq, "R9 irq on", irq, 1);
      irq_en = 1'b0;
      @(negedge clk);
      chk(!irq, "R9 irq masked", irq, 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      @(negedge clk);
      chk(!out_valid, "R5 consumed", out_valid, 0);
      chk(!out_ovr, "R7 ovr cleared", out_ovr, 1'b0);
    end

    // partial slot discarded: R10
    send_slot(~cur, 32'h00AB, 8);
    send_slot(~cur, 32'h3C3C, 16);
    end_slot();
    repeat (10) @(negedge clk);
    chk(out_valid && out_data == 16'h3C3C, "R10 partial", out_data, 16'h3C3C);
    chk(!out_ovr, "R10 no ovr", out_ovr, 0);
    drain();

    // disabled receiver: R11, then restart needs a fresh WS change (R10)
    en = 1'b0;
    send_slot(~cur, 32'h4444, 16);
    send_slot(~cur, 32'h5555, 16);
    end_slot();
    repeat (10) @(negedge clk);
    chk(!out_valid, "R11 disabled", out_valid, 0);
    en = 1'b1;
    @(negedge clk);
    send_slot(~cur, 32'h6666, 16);
    send_slot(~cur, 32'h5A5A, 16);
    end_slot();
    repeat (10) @(negedge clk);
    chk(out_valid && out_data == 16'h5A5A, "R11/R10 restart", out_data, 16'h5A5A);
    drain();
    chk(!out_valid, "R5 empty", out_valid, 0);

    // drain and delivery in the same cycle: R8 (delivery lands 4 edges after the bclk rise)
    for (int k = 1; k <= 7; k++) begin
      logic sb;
      send_slot(~cur, 32'hA000 | k, 16);
      send_slot(~cur, 32'hB000 | k, 16);
      sb = cur;
      bclk = 1'b0; ws = ~cur; sd = pend;
      repeat (H) @(negedge clk);
      bclk = 1'b1;
      repeat (k - 1) @(negedge clk);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      cur = ~cur;
      repeat (10) @(negedge clk);
      if (k <= 4) begin
        chk(out_valid && out_data == (16'hB000 | 16'(k)), "R8 kept new", out_data, 16'hB000 | k);
        chk(out_side == sb && !out_ovr, "R8 no ovr", {out_side, out_ovr}, {sb, 1'b0});
      end else begin
        chk(!out_valid && !out_ovr, "R6 late drain", {out_valid, out_ovr}, 0);
      end
      drain();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule